// File: doc/BRIEF.md
# Two-Plane NAND Copy-Back Sequencer

This block runs a two-plane copy-back operation over an 8-bit NAND flash bus. A request names the operation (gather into the page registers, or write back to the array) and two page addresses. Each address is a 16-bit column and a 24-bit row. The block then emits the command and address cycles on the shared I/O bus. It uses a command-latch strobe, an address-latch strobe and an active-low write strobe. It waits out each array-busy interval by reading the status register with an active-low read strobe, and it reports completion. Data is never moved or changed between the two phases.

The gather operation loads both planes in one pass. It sends a setup command and an address for each plane, then a single confirm. The write-back operation sends the first plane's address and a plane-confirm, waits for a short busy, then sends the second address and the final confirm, and waits for the long program busy. Bus timing is set by three cycle-count inputs, so one netlist can serve flash parts of different speeds.

Top module: `nand_cpbk_seq`

## Requirements
- R1: Each page address goes out as five ALE cycles in this order: column bits 7:0, column 15:8, row 7:0, row 15:8, row 23:16.
- R2: A gather request (`req_op`=0) issues command 00h, address of plane A, command 00h, address of plane B, command 35h, then one status wait.
- R3: A write-back request (`req_op`=1) issues 85h, address A, 11h, a status wait, 85h, address B, 10h, and a second status wait.
- R4: A status wait issues command 70h and then one read-strobe cycle at a time until the sampled I/O bit 6 is 1. Only then does the sequence continue or complete.
- R5: If `POLL_LIMIT` consecutive status reads all show bit 6 at 0, the block pulses `done` together with `err` and issues no further bus cycle.
- R6: Command bytes are driven with CLE high and address bytes with ALE high, never both at once. The byte is latched by the rising edge of WE#, and the I/O value is held while WE# is low.
- R7: Every WE# and RE# low pulse lasts max(`cfg_low`,2) clocks. CLE/ALE stay high for max(`cfg_high`,2) clocks after WE# rises.
- R8: CLE or ALE is high, with WE# high, for exactly max(`cfg_setup`,2) clocks before each WE# falling edge.
- R9: `busy` rises in the clock after a request is accepted (`req_valid` high while `busy` is low). `done` is a one-clock pulse in the same clock that `busy` falls.
- R10: A request presented while `busy` is high is ignored. The running operation's bytes are unchanged.
- R11: `nand_io_oe` is high exactly while CLE or ALE is high, and it is low during every RE# low pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_op | input | 1 | 0 gather to page registers, 1 write back |
| req_col_a | input | 16 | Column of plane A page |
| req_row_a | input | 24 | Row of plane A page |
| req_col_b | input | 16 | Column of plane B page |
| req_row_b | input | 24 | Row of plane B page |
| cfg_low | input | CNT_W | Strobe low width in clocks (min 2) |
| cfg_high | input | CNT_W | Strobe high / latch hold width (min 2) |
| cfg_setup | input | CNT_W | Latch-to-WE# setup in clocks (min 2) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock completion pulse |
| err | output | 1 | With done: status wait timed out |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | Byte driven onto the I/O bus |
| nand_io_oe | output | 1 | Output enable for the I/O bus |
| nand_io_in | input | 8 | Byte read from the I/O bus |

## Verification
The bench varies the number of not-ready status reads before ready. It includes the case one short of the timeout limit, which must still finish cleanly, and the case at the limit, which must stop with `err`. A design off by one in its poll count would flip these two outcomes. Not-ready reads carry random values in every bit except bit 6, so a design that tests the wrong bit, or the whole byte, would end a wait too early or hang. Timing inputs of 0 and 1 test the two-clock floor, and a request pushed in mid-operation checks that the byte stream is not disturbed by a re-latched address.

// File: rtl/nand_cpbk_pkg.sv
package nand_cpbk_pkg;

    localparam int COL_W      = 16;
    localparam int ROW_W      = 24;
    localparam int IDX_W      = 4;
    localparam int READY_BIT  = 6;
    localparam int MIN_CYC    = 2;

    localparam logic [7:0] OP_GATHER   = 8'h00;
    localparam logic [7:0] OP_GATH_GO  = 8'h35;
    localparam logic [7:0] OP_WRBACK   = 8'h85;
    localparam logic [7:0] OP_PLANE_GO = 8'h11;
    localparam logic [7:0] OP_WR_GO    = 8'h10;
    localparam logic [7:0] OP_STATUS   = 8'h70;

    typedef enum logic [1:0] {BK_CMD, BK_ADDR, BK_READ} bus_kind_e;
    typedef enum logic [1:0] {ST_CMD, ST_ADDR, ST_WAIT} step_kind_e;
    typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_LOW, PH_HIGH} phase_e;
    typedef enum logic [2:0] {SQ_IDLE, SQ_ISSUE, SQ_BUS, SQ_POLL, SQ_POLL_BUS} seq_state_e;

    typedef struct packed {
        step_kind_e  kind;
        logic [7:0]  data;
        logic        last;
    } step_t;

    typedef struct packed {
        seq_state_e        state;
        logic              op;
        logic [COL_W-1:0]  col_a;
        logic [ROW_W-1:0]  row_a;
        logic [COL_W-1:0]  col_b;
        logic [ROW_W-1:0]  row_b;
        logic [IDX_W-1:0]  idx;
        logic              done;
        logic              err;
    } seq_s;

    // Byte sel of a page address: 0,1 column (low first), 2..4 row (low first)
    function automatic logic [7:0] addr_byte(logic [COL_W-1:0] col,
                                             logic [ROW_W-1:0] row,
                                             logic [2:0] sel);
        case (sel)
            3'd0:    return col[7:0];
            3'd1:    return col[15:8];
            3'd2:    return row[7:0];
            3'd3:    return row[15:8];
            default: return row[23:16];
        endcase
    endfunction

    function automatic step_t mk(step_kind_e k, logic [7:0] b, logic l);
        step_t s;
        s.kind = k;
        s.data = b;
        s.last = l;
        return s;
    endfunction

    // Step table of both operations, indexed by position in the sequence
    function automatic step_t step_at(logic op, logic [IDX_W-1:0] idx,
                                      logic [COL_W-1:0] ca, logic [ROW_W-1:0] ra,
                                      logic [COL_W-1:0] cb, logic [ROW_W-1:0] rb);
        logic [IDX_W-1:0] off1;
        logic [IDX_W-1:0] off7;
        logic [IDX_W-1:0] off9;
        off1 = idx - IDX_W'(1);
        off7 = idx - IDX_W'(7);
        off9 = idx - IDX_W'(9);
        if (!op) begin
            if (idx == IDX_W'(0))       return mk(ST_CMD, OP_GATHER, 1'b0);
            else if (idx <= IDX_W'(5))  return mk(ST_ADDR, addr_byte(ca, ra, off1[2:0]), 1'b0);
            else if (idx == IDX_W'(6))  return mk(ST_CMD, OP_GATHER, 1'b0);
            else if (idx <= IDX_W'(11)) return mk(ST_ADDR, addr_byte(cb, rb, off7[2:0]), 1'b0);
            else if (idx == IDX_W'(12)) return mk(ST_CMD, OP_GATH_GO, 1'b0);
            else                        return mk(ST_WAIT, OP_STATUS, 1'b1);
        end else begin
            if (idx == IDX_W'(0))       return mk(ST_CMD, OP_WRBACK, 1'b0);
            else if (idx <= IDX_W'(5))  return mk(ST_ADDR, addr_byte(ca, ra, off1[2:0]), 1'b0);
            else if (idx == IDX_W'(6))  return mk(ST_CMD, OP_PLANE_GO, 1'b0);
            else if (idx == IDX_W'(7))  return mk(ST_WAIT, OP_STATUS, 1'b0);
            else if (idx == IDX_W'(8))  return mk(ST_CMD, OP_WRBACK, 1'b0);
            else if (idx <= IDX_W'(13)) return mk(ST_ADDR, addr_byte(cb, rb, off9[2:0]), 1'b0);
            else if (idx == IDX_W'(14)) return mk(ST_CMD, OP_WR_GO, 1'b0);
            else                        return mk(ST_WAIT, OP_STATUS, 1'b1);
        end
    endfunction

endpackage

// File: rtl/nand_cpbk_phy.sv
module nand_cpbk_phy
    import nand_cpbk_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  bus_kind_e        kind,
    input  logic [7:0]       wr_byte,
    input  logic [CNT_W-1:0] cfg_low,
    input  logic [CNT_W-1:0] cfg_high,
    input  logic [CNT_W-1:0] cfg_setup,
    input  logic [7:0]       io_in,
    output logic             ack,
    output logic [7:0]       rd_byte,
    output logic             cle,
    output logic             ale,
    output logic             we_n,
    output logic             re_n,
    output logic [7:0]       io_out,
    output logic             io_oe
);

    typedef struct packed {
        phase_e           ph;
        bus_kind_e        kind;
        logic [7:0]       data;
        logic [CNT_W-1:0] cnt;
        logic [7:0]       rd;
    } phy_s;

    phy_s phy_d, phy_q;

    function automatic logic [CNT_W-1:0] span(logic [CNT_W-1:0] v);
        return ((v < CNT_W'(MIN_CYC)) ? CNT_W'(MIN_CYC) : v) - CNT_W'(1);
    endfunction

    always_comb begin
        phy_d = phy_q;
        ack   = 1'b0;
        case (phy_q.ph)
            PH_IDLE: begin
                if (start) begin
                    phy_d.ph   = PH_SETUP;
                    phy_d.kind = kind;
                    phy_d.data = wr_byte;
                    phy_d.cnt  = span(cfg_setup);
                end
            end
            PH_SETUP: begin
                if (phy_q.cnt == '0) begin
                    phy_d.ph  = PH_LOW;
                    phy_d.cnt = span(cfg_low);
                end else begin
                    phy_d.cnt = phy_q.cnt - CNT_W'(1);
                end
            end
            PH_LOW: begin
                if (phy_q.cnt == '0) begin
                    phy_d.ph  = PH_HIGH;
                    phy_d.cnt = span(cfg_high);
                    if (phy_q.kind == BK_READ) phy_d.rd = io_in;
                end else begin
                    phy_d.cnt = phy_q.cnt - CNT_W'(1);
                end
            end
            default: begin
                if (phy_q.cnt == '0) begin
                    phy_d.ph = PH_IDLE;
                    ack      = 1'b1;
                end else begin
                    phy_d.cnt = phy_q.cnt - CNT_W'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phy_q <= '{ph: PH_IDLE, kind: BK_CMD, data: 8'h00, cnt: '0, rd: 8'h00};
        end else begin
            phy_q <= phy_d;
        end
    end

    logic active;
    assign active  = (phy_q.ph != PH_IDLE);
    assign cle     = active && (phy_q.kind == BK_CMD);
    assign ale     = active && (phy_q.kind == BK_ADDR);
    assign io_oe   = active && (phy_q.kind != BK_READ);
    assign we_n    = !((phy_q.ph == PH_LOW) && (phy_q.kind != BK_READ));
    assign re_n    = !((phy_q.ph == PH_LOW) && (phy_q.kind == BK_READ));
    assign io_out  = io_oe ? phy_q.data : 8'h00;
    assign rd_byte = phy_q.rd;

    // R6
    cle_ale_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale));

    // R6
    we_re_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n));

    // R11
    oe_off_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !re_n |-> !io_oe);

    // R6
    io_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && $past(!we_n)) |-> $stable(io_out));

    // R8
    latch_before_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n) |-> $past(cle || ale));

endmodule

// File: rtl/nand_cpbk_poll_timer.sv
module nand_cpbk_poll_timer #(
    parameter int LIMIT = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic miss,
    output logic expired
);

    localparam int W = $clog2(LIMIT + 1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } tmr_s;

    tmr_s tmr_d, tmr_q;

    always_comb begin
        tmr_d   = tmr_q;
        expired = miss && (tmr_q.cnt == W'(LIMIT - 1));
        if (clear) begin
            tmr_d.cnt = '0;
        end else if (miss && !expired) begin
            tmr_d.cnt = tmr_q.cnt + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '{cnt: '0};
        end else begin
            tmr_q <= tmr_d;
        end
    end

    // R5
    poll_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.cnt < W'(LIMIT));

endmodule

// File: rtl/nand_cpbk_seq.sv
module nand_cpbk_seq
    import nand_cpbk_pkg::*;
#(
    parameter int CNT_W      = 4,
    parameter int POLL_LIMIT = 100000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_op,
    input  logic [15:0]      req_col_a,
    input  logic [23:0]      req_row_a,
    input  logic [15:0]      req_col_b,
    input  logic [23:0]      req_row_b,
    input  logic [CNT_W-1:0] cfg_low,
    input  logic [CNT_W-1:0] cfg_high,
    input  logic [CNT_W-1:0] cfg_setup,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic             nand_cle,
    output logic             nand_ale,
    output logic             nand_we_n,
    output logic             nand_re_n,
    output logic [7:0]       nand_io_out,
    output logic             nand_io_oe,
    input  logic [7:0]       nand_io_in
);

    seq_s       seq_d, seq_q;
    step_t      step;
    logic       phy_start;
    bus_kind_e  phy_kind;
    logic [7:0] phy_byte;
    logic       phy_ack;
    logic [7:0] phy_rd;
    logic       tmr_clear;
    logic       tmr_miss;
    logic       tmr_expired;
    logic       ready_seen;

    assign step       = step_at(seq_q.op, seq_q.idx, seq_q.col_a, seq_q.row_a,
                                seq_q.col_b, seq_q.row_b);
    assign ready_seen = phy_rd[READY_BIT];

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        seq_d.err  = 1'b0;
        phy_start  = 1'b0;
        phy_kind   = BK_CMD;
        phy_byte   = step.data;
        tmr_clear  = 1'b0;
        tmr_miss   = 1'b0;
        case (seq_q.state)
            SQ_IDLE: begin
                if (req_valid) begin
                    seq_d.state = SQ_ISSUE;
                    seq_d.op    = req_op;
                    seq_d.col_a = req_col_a;
                    seq_d.row_a = req_row_a;
                    seq_d.col_b = req_col_b;
                    seq_d.row_b = req_row_b;
                    seq_d.idx   = '0;
                end
            end
            SQ_ISSUE: begin
                phy_start   = 1'b1;
                phy_kind    = (step.kind == ST_ADDR) ? BK_ADDR : BK_CMD;
                seq_d.state = SQ_BUS;
            end
            SQ_BUS: begin
                if (phy_ack) begin
                    if (step.kind == ST_WAIT) begin
                        tmr_clear   = 1'b1;
                        seq_d.state = SQ_POLL;
                    end else begin
                        seq_d.idx   = seq_q.idx + IDX_W'(1);
                        seq_d.state = SQ_ISSUE;
                    end
                end
            end
            SQ_POLL: begin
                phy_start   = 1'b1;
                phy_kind    = BK_READ;
                seq_d.state = SQ_POLL_BUS;
            end
            default: begin
                if (phy_ack) begin
                    if (ready_seen) begin
                        if (step.last) begin
                            seq_d.state = SQ_IDLE;
                            seq_d.done  = 1'b1;
                        end else begin
                            seq_d.idx   = seq_q.idx + IDX_W'(1);
                            seq_d.state = SQ_ISSUE;
                        end
                    end else begin
                        tmr_miss = 1'b1;
                        if (tmr_expired) begin
                            seq_d.state = SQ_IDLE;
                            seq_d.done  = 1'b1;
                            seq_d.err   = 1'b1;
                        end else begin
                            seq_d.state = SQ_POLL;
                        end
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: SQ_IDLE, op: 1'b0, col_a: '0, row_a: '0,
                       col_b: '0, row_b: '0, idx: '0, done: 1'b0, err: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy = (seq_q.state != SQ_IDLE);
    assign done = seq_q.done;
    assign err  = seq_q.err;

    nand_cpbk_phy #(
        .CNT_W(CNT_W)
    ) i_phy (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (phy_start),
        .kind      (phy_kind),
        .wr_byte   (phy_byte),
        .cfg_low   (cfg_low),
        .cfg_high  (cfg_high),
        .cfg_setup (cfg_setup),
        .io_in     (nand_io_in),
        .ack       (phy_ack),
        .rd_byte   (phy_rd),
        .cle       (nand_cle),
        .ale       (nand_ale),
        .we_n      (nand_we_n),
        .re_n      (nand_re_n),
        .io_out    (nand_io_out),
        .io_oe     (nand_io_oe)
    );

    nand_cpbk_poll_timer #(
        .LIMIT(POLL_LIMIT)
    ) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (tmr_clear),
        .miss    (tmr_miss),
        .expired (tmr_expired)
    );

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

    // R5
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    // R4
    ready_before_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> $past(phy_rd[READY_BIT]));

    // R10
    req_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(seq_q.col_a) && $stable(seq_q.row_b) && $stable(seq_q.op)));

    // R11
    no_strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (nand_we_n && nand_re_n && !nand_io_oe));

endmodule

// File: tb/test_nand_cpbk_seq.sv
`timescale 1ns/1ps
module test_nand_cpbk_seq;

    localparam int LIMIT = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_op = 1'b0;
    logic [15:0] req_col_a = '0;
    logic [23:0] req_row_a = '0;
    logic [15:0] req_col_b = '0;
    logic [23:0] req_row_b = '0;
    logic [3:0]  cfg_low = 4'd2;
    logic [3:0]  cfg_high = 4'd2;
    logic [3:0]  cfg_setup = 4'd2;
    logic        busy, done, err;
    logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
    logic [7:0]  nand_io_out;
    logic [7:0]  nand_io_in = 8'h00;

    always #2 clk = ~clk;

    nand_cpbk_seq #(.CNT_W(4), .POLL_LIMIT(LIMIT)) i_nand_cpbk_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_col_a(req_col_a), .req_row_a(req_row_a),
        .req_col_b(req_col_b), .req_row_b(req_row_b),
        .cfg_low(cfg_low), .cfg_high(cfg_high), .cfg_setup(cfg_setup),
        .busy(busy), .done(done), .err(err),
        .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
        .nand_re_n(nand_re_n), .nand_io_out(nand_io_out),
        .nand_io_oe(nand_io_oe), .nand_io_in(nand_io_in)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Observed and expected bus logs: {kind, byte}; kind 1 cmd, 2 addr, 3 status read
    logic [9:0] log_q [128];
    logic [9:0] exp_q [128];
    int  log_n = 0, exp_n = 0;
    bit  exp_err = 0;
    int  plan [2];
    int  wait_idx = 0, polls_left = 0;
    int  exp_lo = 2, exp_hi = 2, exp_su = 2;
    bit  done_seen = 0, err_seen = 0;

    function automatic int floor2(int v);
        return (v < 2) ? 2 : v;
    endfunction

    // Bus responder and monitor
    logic [9:0] pend = '0;
    int  we_lo = 0, re_lo = 0, su = 0, hold = 0;
    bit  in_hold = 0;
    logic prev_we = 1'b1, prev_re = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (nand_io_oe !== (nand_cle | nand_ale))
                chk(0, "R11", "oe vs latch strobes", nand_io_oe, nand_cle | nand_ale);
            if (!nand_we_n) begin
                if (prev_we) begin
                    chk(su == exp_su, "R8", "setup clocks", su, exp_su);
                    su = 0;
                end
                we_lo++;
                pend = {nand_cle ? 2'd1 : (nand_ale ? 2'd2 : 2'd0), nand_io_out};
            end else begin
                if (!prev_we) begin
                    chk(we_lo == exp_lo, "R7", "WE low clocks", we_lo, exp_lo);
                    we_lo = 0;
                    if (log_n < 128) log_q[log_n] = pend;
                    log_n++;
                    if (pend[9:8] == 2'd1 &&
                        (pend[7:0] == 8'h35 || pend[7:0] == 8'h11 || pend[7:0] == 8'h10)) begin
                        polls_left = plan[wait_idx];
                        if (wait_idx < 1) wait_idx++;
                    end
                    in_hold = 1;
                    hold = 0;
                end
                if (nand_cle | nand_ale) begin
                    if (in_hold) hold++;
                    else su++;
                end else begin
                    if (in_hold) begin
                        chk(hold == exp_hi, "R7", "latch hold clocks", hold, exp_hi);
                        in_hold = 0;
                    end
                    su = 0;
                end
            end
            if (!nand_re_n) begin
                if (prev_re) begin
                    chk(!nand_io_oe, "R11", "oe during RE low", nand_io_oe, 0);
                    if (polls_left > 0) begin
                        nand_io_in = 8'($urandom) & 8'hBF;
                        polls_left--;
                    end else begin
                        nand_io_in = 8'($urandom) | 8'h40;
                    end
                end
                re_lo++;
            end else if (!prev_re) begin
                chk(re_lo == exp_lo, "R7", "RE low clocks", re_lo, exp_lo);
                re_lo = 0;
                if (log_n < 128) log_q[log_n] = {2'd3, 8'h00};
                log_n++;
            end
            if (done) begin
                done_seen = 1;
                err_seen  = err;
                chk(!busy, "R9", "busy at done", busy, 0);
            end
            prev_we = nand_we_n;
            prev_re = nand_re_n;
        end
    end

    task automatic push_e(logic [1:0] k, logic [7:0] b);
        exp_q[exp_n] = {k, b};
        exp_n++;
    endtask

    task automatic push_addr(logic [15:0] c, logic [23:0] r);
        push_e(2'd2, c[7:0]);   push_e(2'd2, c[15:8]);
        push_e(2'd2, r[7:0]);   push_e(2'd2, r[15:8]); push_e(2'd2, r[23:16]);
    endtask

    // returns 1 when this wait ends in timeout
    task automatic push_wait(int p, output bit to);
        push_e(2'd1, 8'h70);
        to = (p >= LIMIT);
        for (int i = 0; i < (to ? LIMIT : p + 1); i++) push_e(2'd3, 8'h00);
    endtask

    task automatic build(bit op, logic [15:0] ca, logic [23:0] ra,
                         logic [15:0] cb, logic [23:0] rb, int p0, int p1);
        bit to;
        exp_n = 0;
        if (!op) begin
            push_e(2'd1, 8'h00); push_addr(ca, ra);
            push_e(2'd1, 8'h00); push_addr(cb, rb);
            push_e(2'd1, 8'h35); push_wait(p0, to);
            exp_err = to;
        end else begin
            push_e(2'd1, 8'h85); push_addr(ca, ra);
            push_e(2'd1, 8'h11); push_wait(p0, to);
            if (to) begin
                exp_err = 1;
                return;
            end
            push_e(2'd1, 8'h85); push_addr(cb, rb);
            push_e(2'd1, 8'h10); push_wait(p1, to);
            exp_err = to;
        end
    endtask

    task automatic run_op(bit op, logic [15:0] ca, logic [23:0] ra,
                          logic [15:0] cb, logic [23:0] rb, int p0, int p1,
                          logic [3:0] lo, logic [3:0] hi, logic [3:0] sup, bit poke);
        int  cyc;
        int  n_after;
        string tag;
        @(negedge clk);
        cfg_low = lo; cfg_high = hi; cfg_setup = sup;
        exp_lo = floor2(int'(lo)); exp_hi = floor2(int'(hi)); exp_su = floor2(int'(sup));
        build(op, ca, ra, cb, rb, p0, p1);
        log_n = 0; wait_idx = 0; polls_left = 0;
        plan[0] = p0; plan[1] = p1;
        done_seen = 0; err_seen = 0;
        req_valid = 1; req_op = op;
        req_col_a = ca; req_row_a = ra; req_col_b = cb; req_row_b = rb;
        @(negedge clk);
        req_valid = 0;
        chk(busy, "R9", "busy after accept", busy, 1);
        if (poke) begin
            repeat (9) @(negedge clk);
            req_valid = 1; req_op = ~op;
            req_col_a = ~ca; req_row_a = ~ra; req_col_b = ~cb; req_row_b = ~rb;
            @(negedge clk);
            req_valid = 0;
        end
        cyc = 0;
        while (!done_seen && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        if (!done_seen) begin
            chk(0, "R4", "operation never completed", 0, 1);
            rst_n = 0;
            @(negedge clk);
            rst_n = 1;
            return;
        end
        chk(err_seen == exp_err, "R5", "err flag", err_seen, exp_err);
        n_after = log_n;
        repeat (12) @(negedge clk);
        chk(log_n == n_after, "R5", "bus idle after done", log_n, n_after);
        tag = poke ? "R10" : (op ? "R3" : "R2");
        chk(log_n == exp_n, tag, "bus cycle count", log_n, exp_n);
        for (int i = 0; i < exp_n && i < log_n; i++) begin
            if (exp_q[i][9:8] == 2'd2)
                chk(log_q[i] == exp_q[i], "R1", "address cycle", log_q[i], exp_q[i]);
            else if (exp_q[i][9:8] == 2'd3)
                chk(log_q[i] == exp_q[i], "R4", "status read cycle", log_q[i], exp_q[i]);
            else
                chk(log_q[i] == exp_q[i], tag, "command cycle", log_q[i], exp_q[i]);
        end
    endtask

    initial begin
        #800000;
        chk(0, "R4", "watchdog expired", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // reset state
        chk(!busy && !done && !err, "R9", "idle flags in reset", {busy, done, err}, 0);
        chk(nand_we_n && nand_re_n, "R6", "strobes high in reset", {nand_we_n, nand_re_n}, 3);
        chk(!nand_cle && !nand_ale && !nand_io_oe, "R11", "latches/oe low in reset",
            {nand_cle, nand_ale, nand_io_oe}, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        chk(!busy, "R9", "idle after reset", busy, 0);

        // directed: gather with distinct bytes
        run_op(1'b0, 16'hB2A1, 24'hE5D4C3, 16'h1807, 24'h4B3A29, 2, 0, 4'd2, 4'd2, 4'd2, 0);
        // directed: write back, both waits
        run_op(1'b1, 16'h0F0E, 24'h131211, 16'h2120, 24'h343332, 3, 1, 4'd3, 4'd2, 4'd4, 0);
        // timing floor: zero and one clamp to two
        run_op(1'b1, 16'h5A5A, 24'hA5A5A5, 16'h0001, 24'h800000, 0, 0, 4'd0, 4'd1, 4'd0, 0);
        // one short of the poll limit still succeeds
        run_op(1'b0, 16'h7777, 24'h666666, 16'h8888, 24'h999999, LIMIT - 1, 0, 4'd2, 4'd3, 4'd2, 0);
        // R5 timeout in the plane-confirm wait
        run_op(1'b1, 16'h1234, 24'h56789A, 16'hBCDE, 24'hF01234, 1000, 0, 4'd2, 4'd2, 4'd3, 0);
        // R5 timeout in the final wait
        run_op(1'b1, 16'h4321, 24'hA98765, 16'hEDCB, 24'h43210F, 1, LIMIT, 4'd2, 4'd2, 4'd2, 0);
        // R10 request during an operation
        run_op(1'b0, 16'hC0DE, 24'hBEEF01, 16'hFACE, 24'h123456, 1, 0, 4'd2, 4'd2, 4'd2, 1);
        run_op(1'b1, 16'h00FF, 24'hFF00FF, 16'hFF00, 24'h00FF00, 2, 2, 4'd5, 4'd4, 4'd3, 1);

        // constrained random
        for (int k = 0; k < 14; k++) begin
            run_op(1'($urandom), 16'($urandom), 24'($urandom), 16'($urandom), 24'($urandom),
                   int'($urandom % 6), int'($urandom % 6),
                   4'($urandom % 6), 4'($urandom % 6), 4'($urandom % 6), 1'($urandom % 4 == 0));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule